// File: doc/BRIEF.md
# Masked Frame Header Aligner

The aligner takes a recovered serial stream, one bit per clock, and searches it for a programmable frame header. When the header is seen, it re-anchors the parallel word boundary so that every later word starts on the bit right after the header. One word length later, on the first fully aligned word, it emits a single-cycle frame pulse. The search compares either the full 32-bit header or only its low 10 bits. The choice follows the word-length mode: 16-bit words or 10-bit words. Any header bit can be excluded from the comparison with a per-bit don't-care mask, which allows short or gapped headers.

Alignment is enabled by a dedicated pin, or by a pair of configuration bits that must both be set. The header and the mask are each written one byte at a time. Internally, a free-running phase counter counts modulo the word length. The boundary offset reported on the output is the phase at which the last header bit arrived. A word strobe marks the clock in which each parallel word completes.

Top module: `fha_aligner`

## Requirements
- R1: Alignment is active when `align_pin` is 1, or when both `cfg_override` and `cfg_align_en` are 1; in every other combination a header causes no re-anchoring and no frame pulse.
- R2: With `narrow_mode` = 0, a match needs all 32 unmasked bits of the window to equal the pattern. The window holds the last 32 received bits, with the newest bit at bit 0, so a header sent most-significant bit first matches on its final bit.
- R3: With `narrow_mode` = 1, only window bits 9..0 are compared against pattern bits 9..0, and pattern bits 31..10 have no effect.
- R4: A mask bit of 1 makes that header position match whatever bit is received; a mask bit of 0 requires equality.
- R5: Reset sets the pattern to 32'hF6F62828 and the mask to all zeros, clears `boundary_off`, `word_stb` and `frame_pulse`, and restarts the phase counter at 0.
- R6: A write with `cfg_we` = 1 loads `cfg_byte` into bits 8k+7..8k, where k = `cfg_idx`. The target is the pattern when `cfg_sel` = 0 and the mask when `cfg_sel` = 1. The write takes effect from the next clock.
- R7: On an active match in the clock that receives bit number s after reset (counting from 0), `boundary_off` becomes s mod L in the next cycle, and `word_stb` is 1. Here L = 16 when `narrow_mode` = 0 and L = 10 when `narrow_mode` = 1.
- R8: After the last boundary (or after reset, counting from bit −1), `word_stb` is 1 exactly on every L-th received bit.
- R9: `frame_pulse` is 1 for one cycle, L bits after the most recent active match, and it coincides with `word_stb`. A new match before then restarts the count, and the earlier match then produces no pulse.
- R10: While alignment is inactive, `boundary_off` holds its value, no frame pulse appears, a pending pulse is dropped, and `word_stb` continues on the old boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Recovered serial data bit |
| align_pin | input | 1 | Alignment enable from a pin |
| cfg_override | input | 1 | Configuration override bit for the enable |
| cfg_align_en | input | 1 | Configuration enable bit |
| narrow_mode | input | 1 | 1: 10-bit words and 10-bit header; 0: 16-bit words and 32-bit header |
| cfg_we | input | 1 | Header or mask byte write strobe |
| cfg_sel | input | 1 | 0 selects the pattern, 1 selects the mask |
| cfg_idx | input | 2 | Byte number 0..3 |
| cfg_byte | input | 8 | Byte to write |
| boundary_off | output | 4 | Phase of the last header bit |
| word_stb | output | 1 | Parallel word completes this cycle |
| frame_pulse | output | 1 | First aligned word after a header |

## Verification
Two functions can land in the same cycle. The first is a new header match. The second is the word-boundary wrap that would release a pending frame pulse. The bench provokes this collision by sending a short masked header and then repeating it before one word length has passed. It also sweeps the header across every phase, so that some matches fall exactly on old boundary cycles. In every case the new match must win: the strobe marks the new boundary, and the only pulse comes exactly L bits after the second match.

// File: rtl/fha_pkg.sv
package fha_pkg;
  localparam int HDR_BITS    = 32;
  localparam int SHORT_BITS  = 10;
  localparam int WORD_WIDE   = 16;
  localparam int WORD_NARROW = 10;
  localparam int BYTE_BITS   = 8;
  // Middle section of an SDH/SONET frame alignment word
  localparam logic [HDR_BITS-1:0] HDR_DEFAULT = 32'hF6F6_2828;
endpackage

// File: rtl/fha_hdr_regs.sv
module fha_hdr_regs #(
  parameter int HDR_W  = 32,
  parameter int BYTE_W = 8,
  parameter logic [HDR_W-1:0] DEF_PAT = '0,
  localparam int NB   = HDR_W / BYTE_W,
  localparam int IW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel,
  input  logic [IW-1:0]     idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [HDR_W-1:0]  pattern_o,
  output logic [HDR_W-1:0]  mask_o
);
  logic [HDR_W-1:0] pat_q, msk_q;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        pat_q[g*BYTE_W +: BYTE_W] <= DEF_PAT[g*BYTE_W +: BYTE_W];
        msk_q[g*BYTE_W +: BYTE_W] <= '0;
      end else if (we && (idx == IW'(g))) begin
        if (sel) msk_q[g*BYTE_W +: BYTE_W] <= wdata;
        else     pat_q[g*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

  assign pattern_o = pat_q;
  assign mask_o    = msk_q;

  assert_pat_write_R6: assert property (@(posedge clk) disable iff (rst)
    (we && !sel) |=> (pat_q[$past(idx)*BYTE_W +: BYTE_W] == $past(wdata)));
  assert_mask_write_R6: assert property (@(posedge clk) disable iff (rst)
    (we && sel) |=> (msk_q[$past(idx)*BYTE_W +: BYTE_W] == $past(wdata)));
endmodule

// File: rtl/fha_matcher.sv
module fha_matcher #(
  parameter int HDR_W   = 32,
  parameter int SHORT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             narrow,
  input  logic [HDR_W-1:0] pattern,
  input  logic [HDR_W-1:0] mask,
  output logic             hit_o
);
  logic [HDR_W-1:0] win_q;
  logic [HDR_W-1:0] window_c;
  logic [HDR_W-1:0] eq_c;

  // Newest bit enters at bit 0
  assign window_c = {win_q[HDR_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else     win_q <= window_c;
  end

  for (genvar i = 0; i < HDR_W; i++) begin : g_cmp
    assign eq_c[i] = mask[i] | ~(window_c[i] ^ pattern[i]);
  end

  if (SHORT_W < HDR_W) begin : g_two_len
    assign hit_o = narrow ? (&eq_c[SHORT_W-1:0]) : (&eq_c);
  end else begin : g_one_len
    assign hit_o = &eq_c;
  end
endmodule

// File: rtl/fha_framer.sv
module fha_framer #(
  parameter int WIDE_WORD   = 16,
  parameter int NARROW_WORD = 10,
  localparam int CW = $clog2(WIDE_WORD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          narrow,
  input  logic          active,
  input  logic          hit,
  output logic [CW-1:0] offset_o,
  output logic          word_stb_o,
  output logic          frame_pulse_o
);
  localparam logic [CW-1:0] WIDE_LAST   = CW'(WIDE_WORD - 1);
  localparam logic [CW-1:0] NARROW_LAST = CW'(NARROW_WORD - 1);

  logic [CW-1:0] ph_q, cnt_q, off_q, last_c;
  logic          pend_q, stb_q, pulse_q;
  logic          take_c, wrap_c, pulse_c;

  assign last_c  = narrow ? NARROW_LAST : WIDE_LAST;
  assign take_c  = active & hit;
  assign wrap_c  = (cnt_q >= last_c);
  assign pulse_c = active & pend_q & wrap_c & ~take_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= '0;
      cnt_q   <= '0;
      off_q   <= '0;
      pend_q  <= 1'b0;
      stb_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      ph_q <= (ph_q >= last_c) ? '0 : ph_q + 1'b1;
      if (take_c) begin
        off_q  <= ph_q;
        cnt_q  <= '0;
        pend_q <= 1'b1;
      end else begin
        cnt_q <= wrap_c ? '0 : cnt_q + 1'b1;
        if (pulse_c || !active) pend_q <= 1'b0;
      end
      stb_q   <= take_c | wrap_c;
      pulse_q <= pulse_c;
    end
  end

  assign offset_o      = off_q;
  assign word_stb_o    = stb_q;
  assign frame_pulse_o = pulse_q;

  assert_pulse_on_stb_R9: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> stb_q);
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  assert_hold_off_R10: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(off_q));
  assert_no_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !active |=> !pulse_q);
  assert_match_stb_R7: assert property (@(posedge clk) disable iff (rst)
    (active && hit) |=> (stb_q && !pulse_q));
endmodule

// File: rtl/fha_aligner.sv
module fha_aligner #(
  parameter int HDR_W       = fha_pkg::HDR_BITS,
  parameter int BYTE_W      = fha_pkg::BYTE_BITS,
  parameter int SHORT_W     = fha_pkg::SHORT_BITS,
  parameter int WIDE_WORD   = fha_pkg::WORD_WIDE,
  parameter int NARROW_WORD = fha_pkg::WORD_NARROW,
  parameter logic [HDR_W-1:0] DEF_PAT = fha_pkg::HDR_DEFAULT,
  localparam int NBYTES = HDR_W / BYTE_W,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int OFF_W  = $clog2(WIDE_WORD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              align_pin,
  input  logic              cfg_override,
  input  logic              cfg_align_en,
  input  logic              narrow_mode,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [BYTE_W-1:0] cfg_byte,
  output logic [OFF_W-1:0]  boundary_off,
  output logic              word_stb,
  output logic              frame_pulse
);
  logic [HDR_W-1:0] pattern, mask;
  logic             hit, active;

  assign active = align_pin | (cfg_override & cfg_align_en);

  fha_hdr_regs #(.HDR_W(HDR_W), .BYTE_W(BYTE_W), .DEF_PAT(DEF_PAT)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .idx(cfg_idx),
    .wdata(cfg_byte), .pattern_o(pattern), .mask_o(mask));

  fha_matcher #(.HDR_W(HDR_W), .SHORT_W(SHORT_W)) u_match (
    .clk(clk), .rst(rst), .bit_in(bit_in), .narrow(narrow_mode),
    .pattern(pattern), .mask(mask), .hit_o(hit));

  fha_framer #(.WIDE_WORD(WIDE_WORD), .NARROW_WORD(NARROW_WORD)) u_frame (
    .clk(clk), .rst(rst), .narrow(narrow_mode), .active(active), .hit(hit),
    .offset_o(boundary_off), .word_stb_o(word_stb), .frame_pulse_o(frame_pulse));
endmodule

// File: tb/sim_fha_aligner.sv
module sim_fha_aligner;
  logic clk = 0, rst = 1, bit_in = 0;
  logic align_pin = 0, cfg_override = 0, cfg_align_en = 0, narrow_mode = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [1:0] cfg_idx = 0;
  logic [7:0] cfg_byte = 0;
  logic [3:0] boundary_off;
  logic word_stb, frame_pulse;

  always #2 clk = ~clk;

  fha_aligner u0 (.clk(clk), .rst(rst), .bit_in(bit_in), .align_pin(align_pin),
    .cfg_override(cfg_override), .cfg_align_en(cfg_align_en), .narrow_mode(narrow_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_byte(cfg_byte),
    .boundary_off(boundary_off), .word_stb(word_stb), .frame_pulse(frame_pulse));

  int errors = 0, checks = 0;
  bit done = 0;
  int s;                 // bit index since reset
  int last_pulse;        // step index of the latest observed pulse
  int npulse;            // pulses seen since last clear
  logic [31:0] mwin, mpat, mmask;
  int mph, mcnt, moff;
  bit mpend;

  function automatic int wlen();
    return narrow_mode ? 10 : 16;
  endfunction

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s step %0d: got %0d expected %0d", tag, s, got, exp);
    end
  endtask

  // One received bit; expected values derived from the requirements
  task automatic step(input logic b);
    logic [31:0] diff;
    bit act, hitm, eb, ep;
    int L;
    bit_in = b;
    @(posedge clk);
    L = wlen();
    mwin = {mwin[30:0], b};
    diff = (mwin ^ mpat) & ~mmask;
    if (narrow_mode) diff = diff & 32'h3FF;              // R3
    hitm = (diff == 0);                                  // R2 R4
    act = align_pin | (cfg_override & cfg_align_en);     // R1
    eb = (act && hitm) || (mcnt >= L-1);                 // R8
    ep = act && mpend && !(act && hitm) && (mcnt >= L-1); // R9
    if (act && hitm) begin moff = mph; mcnt = 0; mpend = 1; end
    else begin
      mcnt = (mcnt >= L-1) ? 0 : mcnt + 1;
      if (ep || !act) mpend = 0;                         // R10
    end
    mph = (mph >= L-1) ? 0 : mph + 1;
    if (cfg_we) begin                                    // R6
      if (cfg_sel) mmask[cfg_idx*8 +: 8] = cfg_byte;
      else         mpat[cfg_idx*8 +: 8]  = cfg_byte;
    end
    @(negedge clk);
    chk(word_stb == eb, "R8 word_stb", word_stb, eb);
    chk(frame_pulse == ep, "R9 frame_pulse", frame_pulse, ep);
    chk(boundary_off == moff[3:0], "R7 boundary_off", boundary_off, moff);
    if (frame_pulse) begin last_pulse = s; npulse++; end
    s++;
  endtask

  task automatic apply_reset(input bit narrow);
    @(negedge clk);
    rst = 1; bit_in = 0; cfg_we = 0; narrow_mode = narrow;
    repeat (3) @(negedge clk);
    rst = 0;
    mwin = 0; mpat = 32'hF6F62828; mmask = 0; mph = 0; mcnt = 0; moff = 0; mpend = 0;
    s = 0; npulse = 0; last_pulse = -1;
    chk(boundary_off == 0, "R5 reset offset", boundary_off, 0);
    chk(word_stb == 0, "R5 reset strobe", word_stb, 0);
    chk(frame_pulse == 0, "R5 reset pulse", frame_pulse, 0);
  endtask

  task automatic wr(input bit sel, input int idx, input logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_idx = idx[1:0]; cfg_byte = d;
    step(0);
    cfg_we = 0;
  endtask

  task automatic send(input logic [31:0] h, input int n);
    for (int i = n - 1; i >= 0; i--) step(h[i]);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) step(0);
  endtask

  // Sends a header, then checks offset and a single pulse L bits later
  task automatic hdr_case(input logic [31:0] h, input int n, input bit expect_hit,
                          input string tag);
    int m, L, off_before;
    L = wlen();
    off_before = boundary_off;
    send(h, n);
    m = s - 1;
    if (expect_hit) chk(boundary_off == m % L, {tag, " R7 offset"}, boundary_off, m % L);
    else chk(boundary_off == off_before, {tag, " R10 offset held"}, boundary_off, off_before);
    npulse = 0;
    zeros(L + 2);
    chk(npulse == (expect_hit ? 1 : 0), {tag, " R9 pulse count"}, npulse, expect_hit ? 1 : 0);
    if (expect_hit) chk(last_pulse == m + L, {tag, " R9 pulse timing"}, last_pulse, m + L);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R5 R2: default header in wide mode, every phase
    apply_reset(0);
    align_pin = 1;
    for (int p = 0; p < 16; p++) begin
      zeros(p);
      hdr_case(32'hF6F62828, 32, 1, "R5 R2 wide sweep");
    end
    // R2: one high bit wrong -> no match
    hdr_case(32'h76F62828, 32, 0, "R2 bit31 flipped");

    // R4 R6: mask out upper 16 bits; only 0x2828 must match
    wr(1, 2, 8'hFF); wr(1, 3, 8'hFF);
    zeros(5);
    hdr_case(32'h00002828, 16, 1, "R4 R6 masked upper");

    // R9: short header (low byte A5) repeated inside one word length
    wr(1, 1, 8'hFF); wr(0, 0, 8'hA5);
    zeros(7);
    send(32'hA5, 8); zeros(4);
    begin
      int m2;
      npulse = 0;
      send(32'hA5, 8);
      m2 = s - 1;
      zeros(18);
      chk(npulse == 1, "R9 rematch single pulse", npulse, 1);
      chk(last_pulse == m2 + 16, "R9 rematch timing", last_pulse, m2 + 16);
    end

    // R1 R10: all enable combinations with the default header
    apply_reset(0);
    for (int c = 0; c < 8; c++) begin
      bit a;
      align_pin = c[2]; cfg_override = c[1]; cfg_align_en = c[0];
      a = c[2] | (c[1] & c[0]);
      zeros(3 + c);
      hdr_case(32'hF6F62828, 32, a, a ? "R1 enabled" : "R1 R10 disabled");
    end

    // R3: narrow mode, 10-bit header 0x2B5 at every phase; upper pattern bytes ignored
    apply_reset(1);
    align_pin = 1; cfg_override = 0; cfg_align_en = 0;
    wr(0, 0, 8'hB5); wr(0, 1, 8'h02);
    for (int p = 0; p < 10; p++) begin
      zeros(p + 1);
      hdr_case(32'h2B5, 10, 1, "R3 narrow sweep");
    end
    hdr_case(32'h0B5, 10, 0, "R3 narrow bit9 flipped");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule